// File: doc/BRIEF.md
# Dual-Direction Audio Sample FIFO with DMA Thresholds

This block sits between a host-side data port (register accesses or DMA) and a serial audio shifter. It holds two independent sample queues of 16-bit words. The transmit queue is filled by the host and drained by the shifter. The receive queue is filled by the shifter and drained by the host. Each queue reports how full it is as a count and as four level flags. Each queue also raises a DMA request against a threshold programmed for that direction alone.

Misuse of either queue is detected and recorded. A pop from an empty queue is a starvation error, and a zero sample is returned. A push into a full queue is an overflow error, and the sample is dropped. Both errors and the four level conditions of each queue are captured in a sticky status vector. Software clears a status bit by writing a one to it. Each status bit has its own interrupt enable, and one global enable gates the single interrupt output.

The head of each queue is visible at once (first-word fall-through), so the shifter takes a transmit sample in the same cycle it asks for it. Clearing a queue's enable empties it.

Top module: `audio_fifo_pair`

## Requirements
- R1: Each queue returns its samples in the order they were pushed. A push into a non-full, enabled queue raises its count by one, and a pop from a non-empty, enabled queue lowers it by one, in the cycle after the push or pop. A simultaneous push and pop leave the count unchanged.
- R2: Each level output counts from 0 to DEPTH (32 by default). The level flags are ordered bit 0 empty (count 0), bit 1 almost-empty (count 1 or less), bit 2 full (count DEPTH) and bit 3 almost-full (count DEPTH-1 or more).
- R3: `tx_dma_req` is high exactly while transmit DMA is enabled and the transmit count is at or below `tx_dma_thr`.
- R4: `rx_dma_req` is high exactly while receive DMA is enabled and the receive count is at or above `rx_dma_thr`.
- R5: A shifter request on an empty, enabled transmit queue is a starvation. `tx_shift_data` is zero in that cycle, and the count stays at 0.
- R6: A push into a full, enabled queue is an overflow. The sample is dropped and the queue contents and count are unchanged. This decision uses the count at the start of the cycle, so a push into a full queue is dropped even if a pop happens in the same cycle.
- R7: `rx_rd_word` carries the head sample in bits 15:0 and a data-valid flag in bit 16. When the receive queue is empty or disabled, the word is all zeros.
- R8: While a queue's enable is low, its count is forced to 0 on the next edge, its pushes are ignored, it raises no errors, and its head output reads zero.
- R9: The status bits are laid out as: bits 5:0 receive, bits 11:6 transmit. Within each group the order is empty, almost-empty, full, almost-full, starved, overflow, from bit 0 up. Each bit is set on the edge after its condition holds and stays set until a one is written to it on `stat_clr`. When a clear and a new event meet on the same edge, the event wins.
- R10: `irq` is `irq_glb_en` ANDed with the OR of (`status` AND `irq_src_en`), using the same bit layout as R9.
- R11: After reset both counts are 0, the status vector is 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_fifo_en | input | 1 | Transmit queue enable; low flushes it |
| rx_fifo_en | input | 1 | Receive queue enable; low flushes it |
| tx_dma_en | input | 1 | Transmit DMA request enable |
| rx_dma_en | input | 1 | Receive DMA request enable |
| tx_dma_thr | input | 6 | Transmit request threshold (at or below) |
| rx_dma_thr | input | 6 | Receive request threshold (at or above) |
| irq_glb_en | input | 1 | Global interrupt enable |
| irq_src_en | input | 12 | Per-status-bit interrupt enables |
| stat_clr | input | 12 | Write-one-to-clear strobe for status bits |
| tx_wr_en | input | 1 | Host push into the transmit queue |
| tx_wr_data | input | 16 | Sample pushed by the host |
| tx_shift_req | input | 1 | Shifter takes a transmit sample |
| tx_shift_data | output | 16 | Transmit head sample, zero when empty |
| rx_shift_vld | input | 1 | Shifter delivers a receive sample |
| rx_shift_data | input | 16 | Sample delivered by the shifter |
| rx_rd_en | input | 1 | Host pops the receive queue |
| rx_rd_word | output | 17 | Receive head sample with valid flag in bit 16 |
| tx_level | output | 6 | Transmit occupancy |
| rx_level | output | 6 | Receive occupancy |
| tx_lvl_flags | output | 4 | Transmit level flags |
| rx_lvl_flags | output | 4 | Receive level flags |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| status | output | 12 | Sticky event status |
| irq | output | 1 | Interrupt request |

## Verification
The bench overfills both queues past DEPTH. A design that let the extra sample through, or overwrote the oldest one, would show a wrong count or an out-of-order sample when the queue is drained. It also drains past empty. A design that replayed a stale entry instead of zero, or let the count wrap below zero, would be caught there. It drops a queue's enable with data still inside and writes during the disabled window. A design that kept its pointers or accepted those writes would bring old samples back after re-enabling. Random traffic with random clear strobes hits the case where a clear meets a still-active condition: a design where the clear wins would drop a bit that should read back as set. The bench also moves both thresholds to their extremes, so an off-by-one in either DMA comparison shows up.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    parameter int unsigned AF_DW    = 16;
    parameter int unsigned AF_DEPTH = 32;

    // Per-direction count of sticky status sources.
    localparam int unsigned AF_SRC_PER_DIR = 6;
    localparam int unsigned AF_NSRC        = 2 * AF_SRC_PER_DIR;

    // Level flags, bit 0 = empty up to bit 3 = almost-full.
    typedef struct packed {
        logic afull;
        logic full;
        logic aempty;
        logic empty;
    } afifo_lvl_t;

endpackage

// File: rtl/afifo_lane.sv
module afifo_lane
    import afifo_pkg::*;
#(
    parameter int unsigned DW    = AF_DW,
    parameter int unsigned DEPTH = AF_DEPTH,
    parameter bit          IS_TX = 1'b1,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          dma_en,
    input  logic [CW-1:0] thr,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic          head_vld,
    output logic [CW-1:0] level,
    output afifo_lvl_t    flags,
    output logic          dma_req,
    output logic          starve,
    output logic          ovf
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            rd;
        logic [AW-1:0]            wr;
        logic [CW-1:0]            cnt;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic     is_empty, is_full, take, give;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        is_empty = (st_q.cnt == '0);
        is_full  = (st_q.cnt == CW'(DEPTH));
        // accept/serve decisions use the count held at the start of the cycle
        take     = push & en & ~is_full;
        give     = pop & en & ~is_empty;
        ovf      = push & en & is_full;
        starve   = pop & en & is_empty;

        st_d = st_q;
        if (!en) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (take) begin
                st_d.mem[st_q.wr] = push_data;
                st_d.wr           = ptr_inc(st_q.wr);
            end
            if (give) begin
                st_d.rd = ptr_inc(st_q.rd);
            end
            st_d.cnt = st_q.cnt + CW'(take) - CW'(give);
        end

        head_data    = st_q.mem[st_q.rd];
        head_vld     = en & ~is_empty;
        level        = st_q.cnt;
        flags.empty  = is_empty;
        flags.aempty = (st_q.cnt <= CW'(1));
        flags.full   = is_full;
        flags.afull  = (st_q.cnt >= CW'(DEPTH - 1));
    end

    generate
        if (IS_TX) begin : g_req_low
            assign dma_req = dma_en & (st_q.cnt <= thr);
        end else begin : g_req_high
            assign dma_req = dma_en & (st_q.cnt >= thr);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/afifo_irq.sv
module afifo_irq
    import afifo_pkg::*;
#(
    parameter int unsigned NSRC = AF_NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] ev,
    input  logic [NSRC-1:0] clr,
    input  logic [NSRC-1:0] src_en,
    input  logic            glb_en,
    output logic [NSRC-1:0] status,
    output logic            irq
);

    typedef struct packed {
        logic [NSRC-1:0] stat;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // a fresh event outranks a clear on the same edge
        st_d.stat = (st_q.stat & ~clr) | ev;
        status    = st_q.stat;
        irq       = glb_en & (|(st_q.stat & src_en));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/audio_fifo_pair.sv
module audio_fifo_pair
    import afifo_pkg::*;
#(
    parameter int unsigned DW    = AF_DW,
    parameter int unsigned DEPTH = AF_DEPTH,
    localparam int unsigned CW   = $clog2(DEPTH + 1),
    localparam int unsigned NSRC = AF_NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_fifo_en,
    input  logic            rx_fifo_en,
    input  logic            tx_dma_en,
    input  logic            rx_dma_en,
    input  logic [CW-1:0]   tx_dma_thr,
    input  logic [CW-1:0]   rx_dma_thr,
    input  logic            irq_glb_en,
    input  logic [NSRC-1:0] irq_src_en,
    input  logic [NSRC-1:0] stat_clr,
    input  logic            tx_wr_en,
    input  logic [DW-1:0]   tx_wr_data,
    input  logic            tx_shift_req,
    output logic [DW-1:0]   tx_shift_data,
    input  logic            rx_shift_vld,
    input  logic [DW-1:0]   rx_shift_data,
    input  logic            rx_rd_en,
    output logic [DW:0]     rx_rd_word,
    output logic [CW-1:0]   tx_level,
    output logic [CW-1:0]   rx_level,
    output logic [3:0]      tx_lvl_flags,
    output logic [3:0]      rx_lvl_flags,
    output logic            tx_dma_req,
    output logic            rx_dma_req,
    output logic [NSRC-1:0] status,
    output logic            irq
);

    afifo_lvl_t    tx_f, rx_f;
    logic [DW-1:0] tx_head, rx_head;
    logic          tx_vld, rx_vld;
    logic          tx_stv, tx_ovf, rx_stv, rx_ovf;
    logic [NSRC-1:0] ev;

    afifo_lane #(.DW(DW), .DEPTH(DEPTH), .IS_TX(1'b1)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_fifo_en),
        .dma_en    (tx_dma_en),
        .thr       (tx_dma_thr),
        .push      (tx_wr_en),
        .push_data (tx_wr_data),
        .pop       (tx_shift_req),
        .head_data (tx_head),
        .head_vld  (tx_vld),
        .level     (tx_level),
        .flags     (tx_f),
        .dma_req   (tx_dma_req),
        .starve    (tx_stv),
        .ovf       (tx_ovf)
    );

    afifo_lane #(.DW(DW), .DEPTH(DEPTH), .IS_TX(1'b0)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_fifo_en),
        .dma_en    (rx_dma_en),
        .thr       (rx_dma_thr),
        .push      (rx_shift_vld),
        .push_data (rx_shift_data),
        .pop       (rx_rd_en),
        .head_data (rx_head),
        .head_vld  (rx_vld),
        .level     (rx_level),
        .flags     (rx_f),
        .dma_req   (rx_dma_req),
        .starve    (rx_stv),
        .ovf       (rx_ovf)
    );

    // R5: starved shifter sees zeros; R7: valid flag above the sample
    assign tx_shift_data = tx_vld ? tx_head : '0;
    assign rx_rd_word    = rx_vld ? {1'b1, rx_head} : '0;
    assign tx_lvl_flags  = tx_f;
    assign rx_lvl_flags  = rx_f;

    // R9 layout: receive group low, transmit group high
    assign ev = {tx_ovf, tx_stv, tx_f.afull, tx_f.full, tx_f.aempty, tx_f.empty,
                 rx_ovf, rx_stv, rx_f.afull, rx_f.full, rx_f.aempty, rx_f.empty};

    afifo_irq #(.NSRC(NSRC)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .clr    (stat_clr),
        .src_en (irq_src_en),
        .glb_en (irq_glb_en),
        .status (status),
        .irq    (irq)
    );

endmodule

// File: rtl/afifo_chk.sv
module afifo_chk #(
    parameter int unsigned DW    = 16,
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_fifo_en,
    input logic          tx_wr_en,
    input logic          tx_shift_req,
    input logic [DW-1:0] tx_shift_data,
    input logic [DW:0]   rx_rd_word,
    input logic [CW-1:0] tx_level,
    input logic [CW-1:0] rx_level,
    input logic          irq_glb_en,
    input logic [11:0]   stat_clr,
    input logic [11:0]   status,
    input logic          irq
);

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= CW'(DEPTH)) && (rx_level <= CW'(DEPTH))); // R2

    AST_STARVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_shift_req && tx_level == '0) |-> (tx_shift_data == '0)); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fifo_en && tx_wr_en && !tx_shift_req && tx_level == CW'(DEPTH))
        |=> (tx_level == CW'(DEPTH)) && status[11]); // R6

    AST_RX_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_rd_word[DW] |-> (rx_rd_word[DW-1:0] == '0)); // R7

    AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_fifo_en |=> (tx_level == '0)); // R8

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status) & ~$past(stat_clr) & ~status) == 12'h000)); // R9

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_glb_en |-> !irq); // R10

endmodule

bind audio_fifo_pair afifo_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_fifo_en    (tx_fifo_en),
    .tx_wr_en      (tx_wr_en),
    .tx_shift_req  (tx_shift_req),
    .tx_shift_data (tx_shift_data),
    .rx_rd_word    (rx_rd_word),
    .tx_level      (tx_level),
    .rx_level      (rx_level),
    .irq_glb_en    (irq_glb_en),
    .stat_clr      (stat_clr),
    .status        (status),
    .irq           (irq)
);

// File: tb/tb_audio_fifo_pair.sv
`timescale 1ns/1ps
module tb_audio_fifo_pair;

    localparam int D = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_fifo_en = 0, rx_fifo_en = 0, tx_dma_en = 0, rx_dma_en = 0;
    logic [5:0]  tx_dma_thr = 6'd4, rx_dma_thr = 6'd32;
    logic        irq_glb_en = 0;
    logic [11:0] irq_src_en = '0, stat_clr = '0;
    logic        tx_wr_en = 0, tx_shift_req = 0, rx_shift_vld = 0, rx_rd_en = 0;
    logic [15:0] tx_wr_data = '0, rx_shift_data = '0;
    logic [15:0] tx_shift_data;
    logic [16:0] rx_rd_word;
    logic [5:0]  tx_level, rx_level;
    logic [3:0]  tx_lvl_flags, rx_lvl_flags;
    logic        tx_dma_req, rx_dma_req, irq;
    logic [11:0] status;

    always #2.5 clk = ~clk;

    audio_fifo_pair dut (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [15:0] txq[$];
    logic [15:0] rxq[$];
    logic [11:0] st = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] grp(int n, bit stv, bit ovf);
        return {ovf, stv, n >= D - 1, n == D, n <= 1, n == 0};
    endfunction

    task automatic compare();
        int tn = txq.size();
        int rn = rxq.size();
        chk("R1 R2 tx level", tx_level, tn);
        chk("R1 R2 rx level", rx_level, rn);
        chk("R2 tx flags", tx_lvl_flags, {tn >= D - 1, tn == D, tn <= 1, tn == 0});
        chk("R2 rx flags", rx_lvl_flags, {rn >= D - 1, rn == D, rn <= 1, rn == 0});
        chk("R3 tx dma", tx_dma_req, tx_dma_en && (tn <= tx_dma_thr));
        chk("R4 rx dma", rx_dma_req, rx_dma_en && (rn >= rx_dma_thr));
        chk("R1 R5 tx data", tx_shift_data, (tx_fifo_en && tn > 0) ? txq[0] : 16'h0);
        chk("R7 rx word", rx_rd_word, (rx_fifo_en && rn > 0) ? {1'b1, rxq[0]} : 17'h0);
        chk("R9 status", status, st);
        chk("R10 irq", irq, irq_glb_en && (|(st & irq_src_en)));
    endtask

    task automatic model_edge();
        int tn = txq.size();
        int rn = rxq.size();
        bit t_ovf = tx_wr_en && tx_fifo_en && tn == D;
        bit t_stv = tx_shift_req && tx_fifo_en && tn == 0;
        bit r_ovf = rx_shift_vld && rx_fifo_en && rn == D;
        bit r_stv = rx_rd_en && rx_fifo_en && rn == 0;
        logic [11:0] ev = {grp(tn, t_stv, t_ovf), grp(rn, r_stv, r_ovf)};
        if (!rst_n) begin
            txq.delete(); rxq.delete(); st = '0;
            return;
        end
        if (!tx_fifo_en) txq.delete();
        else begin
            if (tx_shift_req && tn > 0) void'(txq.pop_front());
            if (tx_wr_en && tn < D) txq.push_back(tx_wr_data);
        end
        if (!rx_fifo_en) rxq.delete();
        else begin
            if (rx_rd_en && rn > 0) void'(rxq.pop_front());
            if (rx_shift_vld && rn < D) rxq.push_back(rx_shift_data);
        end
        st = (st & ~stat_clr) | ev;
    endtask

    // called just after a falling edge with inputs settled
    task automatic tick();
        #1;
        compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        tx_wr_en = 0; tx_shift_req = 0; rx_shift_vld = 0; rx_rd_en = 0; stat_clr = '0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        chk("R11 reset tx level", tx_level, 0);
        chk("R11 reset rx level", rx_level, 0);
        chk("R11 reset status", status, 0);
        chk("R11 reset irq", irq, 0);
        rst_n = 1;
        tx_fifo_en = 1; rx_fifo_en = 1; tx_dma_en = 1; rx_dma_en = 1;
        irq_glb_en = 1; irq_src_en = 12'hFFF;
        tick();

        // transmit overfill: 34 pushes into 32 slots
        for (int i = 0; i < 34; i++) begin
            tx_wr_en = 1; tx_wr_data = 16'hA000 + 16'(i); tick();
        end
        idle(); tick();
        chk("R6 tx count after overfill", tx_level, 32);
        chk("R6 tx overflow bit", status[11], 1);
        // drain past empty
        for (int i = 0; i < 34; i++) begin
            tx_shift_req = 1; tick();
        end
        idle(); tick();
        chk("R5 tx starve bit", status[10], 1);
        chk("R5 tx level stays 0", tx_level, 0);

        // receive overfill then read past empty
        for (int i = 0; i < 34; i++) begin
            rx_shift_vld = 1; rx_shift_data = 16'h5000 + 16'(i * 3); tick();
        end
        idle(); tick();
        chk("R6 rx overflow bit", status[5], 1);
        for (int i = 0; i < 34; i++) begin
            rx_rd_en = 1; tick();
        end
        idle(); tick();
        chk("R7 rx starve bit", status[4], 1);

        // clear everything while empty conditions persist
        stat_clr = 12'hFFF; tick();
        idle(); tick();
        chk("R9 empty bits re-set", status & 12'h0C3, 12'h0C3);
        chk("R9 error bits cleared", status & 12'hC30, 12'h000);

        // flush: fill transmit, disable, write while disabled
        for (int i = 0; i < 10; i++) begin
            tx_wr_en = 1; tx_wr_data = 16'h1234 + 16'(i); tick();
        end
        idle(); tx_fifo_en = 0; tick();
        chk("R8 tx flushed", tx_level, 0);
        tx_wr_en = 1; tx_wr_data = 16'hDEAD; tick();
        idle(); tick();
        chk("R8 write while disabled ignored", tx_level, 0);
        chk("R8 head zero while disabled", tx_shift_data, 0);
        tx_fifo_en = 1; tick();

        // threshold extremes and irq gating
        tx_dma_thr = 6'd0; rx_dma_thr = 6'd1; irq_glb_en = 0; tick();
        chk("R10 global off", irq, 0);
        irq_glb_en = 1; irq_src_en = 12'h000; tick();
        chk("R10 no sources", irq, 0);

        // random mixed traffic
        for (int i = 0; i < 600; i++) begin
            tx_wr_en      = ($urandom % 100) < 50;
            tx_wr_data    = 16'($urandom);
            tx_shift_req  = ($urandom % 100) < 45;
            rx_shift_vld  = ($urandom % 100) < 55;
            rx_shift_data = 16'($urandom);
            rx_rd_en      = ($urandom % 100) < 45;
            stat_clr      = (($urandom % 4) == 0) ? 12'($urandom) : 12'h0;
            irq_src_en    = (($urandom % 16) == 0) ? 12'($urandom) : irq_src_en;
            irq_glb_en    = ($urandom % 10) != 0;
            tx_fifo_en    = ($urandom % 60) != 0;
            rx_fifo_en    = ($urandom % 60) != 0;
            tx_dma_en     = ($urandom % 8) != 0;
            rx_dma_en     = ($urandom % 8) != 0;
            if ((i % 100) == 0) begin
                tx_dma_thr = 6'($urandom % 33);
                rx_dma_thr = 6'($urandom % 33);
            end
            tick();
        end
        idle(); tick();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule